// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator

This block decides whether a processor core must take an interrupt trap. It keeps a software interrupt request register and a current priority level register, samples an external interrupt status vector every clock, and, when asked to re-evaluate, finds the highest pending priority level among all requests. If that level beats the current priority, it fires a one-clock trap pulse. With the pulse it gives the value for the interrupt summary register (every pending request bit) and the value for the interrupt identifier register (the winning level).

Privileged code raises `recheck` when it returns to normal execution. That sets an internal evaluation-pending flag, and the next clock runs one evaluation and clears the flag. Software requests use their own compressed range of levels, 1 to 15. External requests use levels equal to their bit positions. A nonzero asynchronous system trap request is not serviced: it is reported on an error output. All pins are plain control and status pins with no stream handshake, because every value is a register snapshot and is never queued.

Top module: `pri_eval_unit`

## Requirements
- R1: A write (`sw_wr_en`) loads the software request register with `sw_wr_data & 0x7fff0`, so only bits 4..18 are kept. `cur_sw_req` shows the register value one cycle after the write.
- R2: A write (`ipl_wr_en`) loads the current priority level register with the low 5 bits of `ipl_wr_data` only. `cur_ipl` shows the register value one cycle after the write.
- R3: A pending software bit i (4..18) stands for level i-3. Among software bits the highest-numbered pending bit sets the software level.
- R4: A pending external bit i (20..30) of `ext_status` stands for level i. If any external bit is pending, the highest one decides the level, whatever software bits are pending. Bits outside 4..18 (software) and 20..30 (external) are ignored.
- R5: On a trap, `isr_value` becomes the OR of all pending software bits (4..18) and external bits (20..30), at their own positions.
- R6: A trap is raised only when the chosen level is nonzero and strictly greater than the current priority. With no trap, `isr_value` and `intid_value` keep their earlier values.
- R7: Evaluation runs only when the pending flag is set. A `recheck` sampled at edge k sets the flag, the evaluation runs at edge k+1 (with `ext_status` as sampled at edge k), and the flag is cleared. Without `recheck`, changing the inputs raises no trap.
- R8: `trap_pulse` is high for exactly one cycle for each evaluation that traps, and `intid_value` shows the winning level in that same cycle.
- R9: `ast_unsupported` is registered and is high one cycle after `ast_req` is nonzero, low one cycle after it is zero.
- R10: After reset every output is zero and no evaluation is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 32 | Software request write value |
| ipl_wr_en | input | 1 | Write strobe for the current priority register |
| ipl_wr_data | input | 32 | Priority write value |
| ext_status | input | 32 | External interrupt status vector |
| recheck | input | 1 | Re-evaluation request on return from privileged code |
| ast_req | input | 4 | Asynchronous trap request register value |
| trap_pulse | output | 1 | One-cycle interrupt trap request |
| isr_value | output | 32 | Value for the interrupt summary register |
| intid_value | output | 5 | Value for the interrupt identifier register |
| ast_unsupported | output | 1 | Asynchronous trap request present |
| cur_sw_req | output | 32 | Software request register contents |
| cur_ipl | output | 5 | Current priority register contents |

## Verification
A wrong pending flag appears at the ports within two cycles of a `recheck`: the trap is missing, comes late, repeats, or fires with no `recheck` at all. A wrong level scan or a wrong comparison appears at the trap cycle, as a bad `intid_value`, a trap where the level equals the priority, or a software level that wins over an external one. Bad masking in the registers appears one cycle after the write on the readback outputs.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  parameter int unsigned ILV_VEC_W  = 32;
  parameter int unsigned ILV_LVL_W  = 5;
  parameter int unsigned ILV_SW_LO  = 4;
  parameter int unsigned ILV_SW_HI  = 18;
  parameter int unsigned ILV_EXT_LO = 20;
  parameter int unsigned ILV_EXT_HI = 30;
  parameter int unsigned ILV_AST_W  = 4;

  function automatic logic [ILV_VEC_W-1:0] span_mask(input int unsigned lo, input int unsigned hi);
    logic [ILV_VEC_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < ILV_VEC_W; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/ilv_ctrl_regs.sv
module ilv_ctrl_regs
  import ilv_pkg::*;
#(
  parameter int unsigned VEC_W = ILV_VEC_W,
  parameter int unsigned LVL_W = ILV_LVL_W,
  parameter int unsigned SW_LO = ILV_SW_LO,
  parameter int unsigned SW_HI = ILV_SW_HI,
  parameter int unsigned AST_W = ILV_AST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [VEC_W-1:0] sw_wr_data,
  input  logic             ipl_wr_en,
  input  logic [VEC_W-1:0] ipl_wr_data,
  input  logic [VEC_W-1:0] ext_in,
  input  logic             recheck,
  input  logic             eval_done,
  input  logic [AST_W-1:0] ast_req,
  output logic [VEC_W-1:0] sw_q,
  output logic [LVL_W-1:0] ipl_q,
  output logic [VEC_W-1:0] ext_q,
  output logic             pend_q,
  output logic             ast_err_q
);
  localparam logic [VEC_W-1:0] SW_KEEP = span_mask(SW_LO, SW_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_q      <= '0;
      ipl_q     <= '0;
      ext_q     <= '0;
      pend_q    <= 1'b0;
      ast_err_q <= 1'b0;
    end else begin
      if (sw_wr_en)  sw_q  <= sw_wr_data & SW_KEEP;
      if (ipl_wr_en) ipl_q <= ipl_wr_data[LVL_W-1:0];
      ext_q     <= ext_in;
      ast_err_q <= |ast_req;
      if (recheck)        pend_q <= 1'b1;
      else if (eval_done) pend_q <= 1'b0;
    end
  end

  assert_sw_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr_en |=> (sw_q == ($past(sw_wr_data) & SW_KEEP)));

  assert_ipl_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_wr_en |=> (ipl_q == $past(ipl_wr_data[LVL_W-1:0])));

  assert_ast_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ast_req) |=> ast_err_q);
endmodule

// File: rtl/ilv_level_scan.sv
module ilv_level_scan
  import ilv_pkg::*;
#(
  parameter int unsigned VEC_W  = ILV_VEC_W,
  parameter int unsigned LVL_W  = ILV_LVL_W,
  parameter int unsigned SW_LO  = ILV_SW_LO,
  parameter int unsigned SW_HI  = ILV_SW_HI,
  parameter int unsigned EXT_LO = ILV_EXT_LO,
  parameter int unsigned EXT_HI = ILV_EXT_HI
) (
  input  logic [VEC_W-1:0] sw_bits,
  input  logic [VEC_W-1:0] ext_bits,
  output logic [LVL_W-1:0] level,
  output logic [VEC_W-1:0] summary
);
  localparam logic [VEC_W-1:0] SW_KEEP  = span_mask(SW_LO, SW_HI);
  localparam logic [VEC_W-1:0] EXT_KEEP = span_mask(EXT_LO, EXT_HI);

  logic [LVL_W-1:0] sw_lvl;
  logic [LVL_W-1:0] ext_lvl;

  always_comb begin
    sw_lvl = '0;
    for (int unsigned i = SW_LO; i <= SW_HI; i++) begin
      if (sw_bits[i]) sw_lvl = LVL_W'(i - SW_LO + 1);
    end
  end

  always_comb begin
    ext_lvl = '0;
    for (int unsigned i = EXT_LO; i <= EXT_HI; i++) begin
      if (ext_bits[i]) ext_lvl = LVL_W'(i);
    end
  end

  assign level   = (ext_lvl != '0) ? ext_lvl : sw_lvl;
  assign summary = (sw_bits & SW_KEEP) | (ext_bits & EXT_KEEP);
endmodule

// File: rtl/ilv_trap_stage.sv
module ilv_trap_stage
  import ilv_pkg::*;
#(
  parameter int unsigned VEC_W = ILV_VEC_W,
  parameter int unsigned LVL_W = ILV_LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_en,
  input  logic [LVL_W-1:0] level,
  input  logic [VEC_W-1:0] summary,
  input  logic [LVL_W-1:0] ipl,
  output logic             trap_q,
  output logic [VEC_W-1:0] isr_q,
  output logic [LVL_W-1:0] intid_q
);
  logic take;
  assign take = eval_en && (level != '0) && (level > ipl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q  <= 1'b0;
      isr_q   <= '0;
      intid_q <= '0;
    end else begin
      trap_q <= take;
      if (take) begin
        isr_q   <= summary;
        intid_q <= level;
      end
    end
  end

  assert_trap_beats_ipl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> (intid_q != '0) && (intid_q > $past(ipl)));

  assert_hold_no_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_q |-> $stable(intid_q));
endmodule

// File: rtl/pri_eval_unit.sv
module pri_eval_unit
  import ilv_pkg::*;
#(
  parameter int unsigned VEC_W  = ILV_VEC_W,
  parameter int unsigned LVL_W  = ILV_LVL_W,
  parameter int unsigned SW_LO  = ILV_SW_LO,
  parameter int unsigned SW_HI  = ILV_SW_HI,
  parameter int unsigned EXT_LO = ILV_EXT_LO,
  parameter int unsigned EXT_HI = ILV_EXT_HI,
  parameter int unsigned AST_W  = ILV_AST_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [VEC_W-1:0] sw_wr_data,
  input  logic             ipl_wr_en,
  input  logic [VEC_W-1:0] ipl_wr_data,
  input  logic [VEC_W-1:0] ext_status,
  input  logic             recheck,
  input  logic [AST_W-1:0] ast_req,
  output logic             trap_pulse,
  output logic [VEC_W-1:0] isr_value,
  output logic [LVL_W-1:0] intid_value,
  output logic             ast_unsupported,
  output logic [VEC_W-1:0] cur_sw_req,
  output logic [LVL_W-1:0] cur_ipl
);
  logic [VEC_W-1:0] sw_q, ext_q, summary;
  logic [LVL_W-1:0] ipl_q, level;
  logic             pend_q;

  ilv_ctrl_regs #(.VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI), .AST_W(AST_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
    .ext_in(ext_status), .recheck(recheck), .eval_done(pend_q),
    .ast_req(ast_req),
    .sw_q(sw_q), .ipl_q(ipl_q), .ext_q(ext_q), .pend_q(pend_q), .ast_err_q(ast_unsupported)
  );

  ilv_level_scan #(.VEC_W(VEC_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI),
                   .EXT_LO(EXT_LO), .EXT_HI(EXT_HI)) u_scan (
    .sw_bits(sw_q), .ext_bits(ext_q), .level(level), .summary(summary)
  );

  ilv_trap_stage #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .eval_en(pend_q),
    .level(level), .summary(summary), .ipl(ipl_q),
    .trap_q(trap_pulse), .isr_q(isr_value), .intid_q(intid_value)
  );

  assign cur_sw_req = sw_q;
  assign cur_ipl    = ipl_q;

  assert_only_after_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> !trap_pulse);

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && !$past(recheck)) |=> !trap_pulse);

  assert_ext_id_in_summary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pulse && intid_value >= LVL_W'(EXT_LO)) |-> isr_value[intid_value]);
endmodule

// File: tb/pri_eval_unit_test.sv
module pri_eval_unit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0, ipl_wr_en = 1'b0, recheck = 1'b0;
  logic [31:0] sw_wr_data = '0, ipl_wr_data = '0, ext_status = '0;
  logic [3:0]  ast_req = '0;
  logic        trap_pulse, ast_unsupported;
  logic [31:0] isr_value, cur_sw_req;
  logic [4:0]  intid_value, cur_ipl;

  int checks = 0, errors = 0;
  logic [31:0] exp_isr = '0, m_sw = '0;
  logic [4:0]  exp_id = '0, m_ipl = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pri_eval_unit uut (
    .clk(clk), .rst_n(rst_n), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data), .ext_status(ext_status),
    .recheck(recheck), .ast_req(ast_req), .trap_pulse(trap_pulse), .isr_value(isr_value),
    .intid_value(intid_value), .ast_unsupported(ast_unsupported),
    .cur_sw_req(cur_sw_req), .cur_ipl(cur_ipl)
  );

  function automatic logic [4:0] ref_level(input logic [31:0] sw, input logic [31:0] ex);
    logic [4:0] l;
    l = '0;
    for (int i = 4; i <= 18; i++) if (sw[i]) l = 5'(i - 3);
    for (int i = 20; i <= 30; i++) if (ex[i]) l = 5'(i);
    return l;
  endfunction

  function automatic logic [31:0] ref_summary(input logic [31:0] sw, input logic [31:0] ex);
    return (sw & 32'h0007_fff0) | (ex & 32'h7ff0_0000);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_sw(input logic [31:0] v);
    sw_wr_en = 1'b1; sw_wr_data = v;
    @(negedge clk);
    sw_wr_en = 1'b0;
    m_sw = v & 32'h0007_fff0;
  endtask

  task automatic wr_ipl(input logic [31:0] v);
    ipl_wr_en = 1'b1; ipl_wr_data = v;
    @(negedge clk);
    ipl_wr_en = 1'b0;
    m_ipl = v[4:0];
  endtask

  // recheck seen at edge k, evaluation at k+1, trap visible after k+1
  task automatic evaluate(input string tag);
    logic [4:0] l;
    logic       t;
    l = ref_level(m_sw, ext_status);
    t = (l != 0) && (l > m_ipl);
    if (t) begin exp_isr = ref_summary(m_sw, ext_status); exp_id = l; end
    recheck = 1'b1;
    @(negedge clk);
    recheck = 1'b0;
    @(negedge clk);
    chk({tag, " trap"}, 32'(trap_pulse), 32'(t));
    chk({tag, " isr"}, isr_value, exp_isr);
    chk({tag, " intid"}, 32'(intid_value), 32'(exp_id));
    @(negedge clk);
    chk({tag, " R8 pulse width"}, 32'(trap_pulse), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 trap", 32'(trap_pulse), 0);
    chk("R10 isr", isr_value, 0);
    chk("R10 intid", 32'(intid_value), 0);
    chk("R10 ast", 32'(ast_unsupported), 0);
    chk("R10 sw", cur_sw_req, 0);
    chk("R10 ipl", 32'(cur_ipl), 0);

    // R6 nothing pending
    evaluate("R6 idle");
    // R1 and R2 masking
    wr_sw(32'hffff_ffff);
    chk("R1 sw mask", cur_sw_req, 32'h0007_fff0);
    wr_ipl(32'h0000_00ff);
    chk("R2 ipl width", 32'(cur_ipl), 32'h1f);
    // R3 highest software bit
    wr_ipl(0);
    wr_sw(32'h0004_0000);
    evaluate("R3 top sw bit");
    chk("R3 level15", 32'(intid_value), 32'd15);
    // R6 level equal to priority: no trap
    wr_ipl(15);
    evaluate("R6 equal");
    wr_ipl(14);
    evaluate("R6 above");
    // R4 R5 mixed: external wins, out-of-range bits ignored
    wr_ipl(15);
    wr_sw(32'h0000_0a30);
    ext_status = 32'h8018_0000 | 32'h0010_0000;
    evaluate("R4 R5 mixed");
    chk("R4 ext wins", 32'(intid_value), 32'd20);
    // R7 no evaluation without recheck
    ext_status = 32'h4000_0000;
    wr_ipl(0);
    repeat (4) begin
      @(negedge clk);
      chk("R7 no recheck", 32'(trap_pulse), 0);
    end
    // R9 asynchronous request
    ast_req = 4'b0100;
    @(negedge clk);
    chk("R9 ast set", 32'(ast_unsupported), 1);
    ast_req = 4'b0000;
    @(negedge clk);
    chk("R9 ast clear", 32'(ast_unsupported), 0);

    // random R3 R4 R5 R6
    for (int n = 0; n < 300; n++) begin
      wr_sw($urandom());
      wr_ipl($urandom());
      ext_status = ($urandom_range(0, 2) == 0) ? $urandom() : ($urandom() & 32'h800f_ffff);
      evaluate("R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule